// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Wait States

This block turns single read or write requests from a processor core into 8080-style external machine cycles. The address bus has 16 bits and the data bus has 8 bits. The core pulses a request that carries an address, write data, a direction bit and an opcode-fetch flag. The sequencer then steps through the T-states: T1 puts the address out, T2 asserts the strobe, optional TW states stretch the cycle, and T3 ends it. After that it pulses `ready` for one clock. For reads, the captured byte is presented on `rdata` in that same clock.

A slow device can stretch a cycle by holding the active-low `wait_n` input. The sequencer samples this input only on the clock edge that ends T2 and on each edge that ends a TW state. The block also decodes an external-reference flag from the cycle address. This flag goes low for addresses from 4096 to 65407 inclusive.

When the bus is idle and `halt` or `hold` is high, or while reset is applied, the output enables drop so that the pads can float the strobes and the address. The data bus is split into `data_out`, `data_oe` and `data_in`, and the bidirectional pad sits at chip level.

Top module: `ext_bus_sequencer`

## Requirements
- R1: While `rst_n` is low, `addr_oe`, `strobe_oe`, `data_oe`, `ready` and `m1` are 0, and `rd_n`, `wr_n` and `offchip_n` are 1.
- R2: A request is taken only when `req` is high at a clock edge where the sequencer is idle and both `halt` and `hold` are low. A `req` pulse at any other time is ignored: it produces no strobe, no `m1` and no `ready`.
- R3: In the cycle after a request is taken (T1), `addr` equals the request address, `addr_oe` is 1, `m1` equals the fetch flag, and both strobes are high. `m1` stays at that value until T3 ends.
- R4: From T2 through T3, `rd_n` is 0 for a read (`req_we`=0) and `wr_n` is 0 for a write (`req_we`=1). The two strobes are never low together, and both are high in T1 and when idle.
- R5: `wait_n` is sampled only at the edge that ends T2 and at each edge that ends a TW state. Each sample of 0 adds one TW clock, so N low samples stretch the strobe by exactly N clocks. Its value in T1 and T3 has no effect.
- R6: `data_oe` is 1, and `data_out` holds the request write data, only from T2 through T3 of a write cycle.
- R7: `ready` is 1 for exactly the one clock that follows T3. For a read, `rdata` then equals `data_in` as sampled at the edge that ends T3.
- R8: `offchip_n` is 0 during T1 through T3 when the cycle address lies in 4096..65407 inclusive. It is 1 for all other addresses and whenever the sequencer is idle.
- R9: When idle with `halt` or `hold` high, `addr_oe` and `strobe_oe` are 0. A cycle already in progress runs to completion with its drivers enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 1 | Core halted; floats the bus when idle |
| hold | input | 1 | Bus hold request; floats the bus when idle |
| req | input | 1 | Cycle request pulse from the core |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_we | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Cycle is an opcode fetch |
| ready | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with `ready` |
| wait_n | input | 1 | Wait request, active low |
| addr | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_out | output | 8 | Data bus value for writes |
| data_oe | output | 1 | Data bus drive enable |
| data_in | input | 8 | Data bus value from the pads |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Strobe drive enable |
| m1 | output | 1 | Opcode-fetch cycle indicator |
| offchip_n | output | 1 | Low for addresses in the external window |

## Verification
The hardest case to provoke from the ports is a wait input that changes at exactly the right T-states. It must be low during T1 to show that it is not sampled there, released on the last TW clock, and changed again in T3. The stimulus drives `wait_n` from inside the cycle task, keyed to the T-state the bench expects, with a random stretch of zero to three clocks. Requests are also injected while a cycle is in flight and while `hold` or `halt` is raised in the middle of a cycle. Random addresses are mixed with the window edges 4095, 4096, 65407 and 65408.

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int EXT_LO = 4096,
  parameter int EXT_HI = 65407
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          hold,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_we,
  input  logic          req_fetch,
  output logic          ready,
  output logic [DW-1:0] rdata,
  input  logic          wait_n,
  output logic [AW-1:0] addr,
  output logic          addr_oe,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [DW-1:0] data_in,
  output logic          rd_n,
  output logic          wr_n,
  output logic          strobe_oe,
  output logic          m1,
  output logic          offchip_n
);

  localparam logic [AW-1:0] WIN_LO = EXT_LO[AW-1:0];
  localparam logic [AW-1:0] WIN_HI = EXT_HI[AW-1:0];

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3} tstate_t;

  tstate_t       st;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic          we_q, fe_q;

  wire parked = halt | hold;
  wire active = (st != S_IDLE);
  wire strobe_ph = (st == S_T2) | (st == S_TW) | (st == S_T3);
  wire drive_en = rst_n & (active | ~parked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      wd_q  <= '0;
      we_q  <= 1'b0;
      fe_q  <= 1'b0;
      ready <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= (st == S_T3);
      if (st == S_T3 && !we_q) rdata <= data_in;
      case (st)
        S_IDLE: if (req && !parked) begin
          a_q  <= req_addr;
          wd_q <= req_wdata;
          we_q <= req_we;
          fe_q <= req_fetch;
          st   <= S_T1;
        end
        S_T1:    st <= S_T2;
        S_T2,
        S_TW:    st <= wait_n ? S_T3 : S_TW;
        S_T3:    st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign addr      = a_q;
  assign addr_oe   = drive_en;
  assign strobe_oe = drive_en;
  assign rd_n      = ~(strobe_ph & ~we_q);
  assign wr_n      = ~(strobe_ph & we_q);
  assign data_oe   = strobe_ph & we_q;
  assign data_out  = wd_q;
  assign m1        = active & fe_q;
  assign offchip_n = ~(active & (a_q >= WIN_LO) & (a_q <= WIN_HI));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_wait_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_T2 || st == S_TW) && !wait_n) |=> (st == S_TW && $stable(rd_n) && $stable(wr_n)));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  p_data_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!wr_n && rd_n));

  p_float_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1 && rd_n && wr_n && !strobe_oe) |-> !addr_oe);

  p_cycle_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(rd_n && wr_n && addr_oe));

endmodule

// File: tb/ext_bus_sequencer_test.sv
module ext_bus_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0, hold = 1'b0, req = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_we = 1'b0, req_fetch = 1'b0;
  logic        wait_n = 1'b1;
  logic [7:0]  data_in = '0;
  logic        ready, addr_oe, data_oe, rd_n, wr_n, strobe_oe, m1, offchip_n;
  logic [7:0]  rdata, data_out;
  logic [15:0] addr;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  ext_bus_sequencer uut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .hold(hold), .req(req),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we), .req_fetch(req_fetch),
    .ready(ready), .rdata(rdata), .wait_n(wait_n), .addr(addr), .addr_oe(addr_oe),
    .data_out(data_out), .data_oe(data_oe), .data_in(data_in), .rd_n(rd_n), .wr_n(wr_n),
    .strobe_oe(strobe_oe), .m1(m1), .offchip_n(offchip_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_off(input logic [15:0] a);
    return !(a >= 16'd4096 && a <= 16'd65407);
  endfunction

  task automatic run_cycle(input logic [15:0] a, input bit we, input bit fe,
                           input logic [7:0] wd, input int nw, input bit hold_mid,
                           input bit poke);
    logic [7:0] rv;
    rv = 8'($urandom);
    req = 1'b1; req_addr = a; req_we = we; req_fetch = fe; req_wdata = wd;
    wait_n = 1'b0;
    @(negedge clk);
    chk(addr == a && addr_oe, "R3 address in T1", {16'h0, addr}, {16'h0, a});
    chk(m1 == fe, "R3 m1 in T1", m1, fe);
    chk(rd_n && wr_n, "R4 strobes high in T1", {rd_n, wr_n}, 2'b11);
    chk(offchip_n == exp_off(a), "R8 offchip in T1", offchip_n, exp_off(a));
    chk(!ready, "R7 ready single pulse", ready, 0);
    req = 1'b0; req_addr = ~a; req_wdata = ~wd; req_we = ~we; req_fetch = ~fe;
    if (hold_mid) begin hold = 1'b1; halt = 1'b1; end
    @(negedge clk);
    chk(rd_n == we && wr_n == !we, "R4 strobe in T2", {rd_n, wr_n}, {we, !we});
    chk(data_oe == we && (!we || data_out == wd), "R6 write data in T2", {data_oe, data_out}, {we, wd});
    chk(strobe_oe && addr_oe, "R9 drivers on mid-cycle", {strobe_oe, addr_oe}, 2'b11);
    wait_n = (nw == 0);
    if (poke) begin req = 1'b1; req_fetch = 1'b1; end
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      req = 1'b0;
      chk(rd_n == we && wr_n == !we && !ready, "R5 wait state holds strobe", {rd_n, wr_n, ready}, {we, !we, 1'b0});
      chk(m1 == fe && offchip_n == exp_off(a), "R3 m1 held in TW", m1, fe);
      if (i == nw - 1) wait_n = 1'b1;
    end
    @(negedge clk);
    req = 1'b0;
    chk(rd_n == we && wr_n == !we && !ready, "R5 T3 after waits", {rd_n, wr_n, ready}, {we, !we, 1'b0});
    chk(data_oe == we, "R6 data drive in T3", data_oe, we);
    data_in = rv;
    wait_n = 1'($urandom);
    @(negedge clk);
    chk(ready, "R7 ready after T3", ready, 1);
    if (!we) chk(rdata == rv, "R7 read data", rdata, rv);
    chk(rd_n && wr_n && !data_oe && !m1 && offchip_n, "R8 idle outputs",
        {rd_n, wr_n, data_oe, m1, offchip_n}, 5'b11001);
    data_in = 8'($urandom);
    wait_n = 1'b1;
    if (hold_mid) begin
      chk(!strobe_oe && !addr_oe, "R9 float after cycle under hold", {strobe_oe, addr_oe}, 0);
      hold = 1'b0; halt = 1'b0;
    end
    if (poke) begin
      @(negedge clk);
      chk(!ready && rd_n && wr_n && !m1, "R2 request during busy ignored", {ready, rd_n, wr_n, m1}, 4'b0110);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [6];
    edges[0] = 16'd4095; edges[1] = 16'd4096; edges[2] = 16'd65407;
    edges[3] = 16'd65408; edges[4] = 16'h0000; edges[5] = 16'hFFFF;
    void'($urandom(32'd1234));
    req = 1'b1;
    repeat (3) @(negedge clk);
    chk(!addr_oe && !strobe_oe && !data_oe && !ready && !m1, "R1 enables off in reset",
        {addr_oe, strobe_oe, data_oe, ready, m1}, 0);
    chk(rd_n && wr_n && offchip_n, "R1 strobes high in reset", {rd_n, wr_n, offchip_n}, 3'b111);
    req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(addr_oe && strobe_oe && !ready, "R1 idle after reset", {addr_oe, strobe_oe, ready}, 3'b110);

    run_cycle(16'd4096, 1'b0, 1'b1, 8'h00, 0, 1'b0, 1'b0);
    run_cycle(16'd4095, 1'b1, 1'b0, 8'hA5, 2, 1'b0, 1'b0);
    run_cycle(16'd65407, 1'b0, 1'b0, 8'h00, 1, 1'b0, 1'b0);
    run_cycle(16'd65408, 1'b1, 1'b1, 8'h3C, 3, 1'b0, 1'b0);
    run_cycle(16'h1234, 1'b0, 1'b1, 8'h00, 1, 1'b0, 1'b1);
    run_cycle(16'h0010, 1'b1, 1'b0, 8'h77, 0, 1'b1, 1'b0);

    hold = 1'b1; req = 1'b1; req_fetch = 1'b1; req_addr = 16'h2000;
    @(negedge clk);
    chk(!strobe_oe && !addr_oe, "R9 hold floats idle bus", {strobe_oe, addr_oe}, 0);
    chk(rd_n && wr_n && !m1, "R2 request under hold ignored", {rd_n, wr_n, m1}, 3'b110);
    hold = 1'b0; halt = 1'b1;
    @(negedge clk);
    chk(!strobe_oe && !addr_oe && !m1, "R9 halt floats idle bus", {strobe_oe, addr_oe, m1}, 0);
    req = 1'b0; halt = 1'b0;
    @(negedge clk);
    chk(strobe_oe && addr_oe && !m1 && !ready, "R2 no cycle started", {strobe_oe, addr_oe, m1, ready}, 4'b1100);

    for (int n = 0; n < 40; n++) begin
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? edges[$urandom % 6] : 16'($urandom);
      run_cycle(a, 1'($urandom), 1'($urandom), 8'($urandom), int'($urandom % 4),
                ($urandom % 8 == 0), ($urandom % 8 == 0));
    end

    rst_n = 1'b0;
    #1;
    chk(!addr_oe && !strobe_oe && !ready, "R1 reset reapplied", {addr_oe, strobe_oe, ready}, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule